// File: doc/BRIEF.md
# Serial-In Parallel-Out Channel Driver with Polarity and Blanking

This block turns a serial bit stream into a set of on/off controls, one for each channel. It is meant for display and print-head drivers. Bits enter a shift register. Each falling transition of a serial clock moves them one stage. A bank of holding registers takes a copy of the shift register under a load control. A per-channel output stage then applies a polarity inversion and a global blanking override. The final shift stage also drives a serial output, so several blocks can be chained into one longer register.

Everything runs on a single system clock. The serial clock and the load control are treated as ordinary inputs that are sampled on that clock. A falling transition of the serial clock is detected when it is seen high on one system-clock edge and low on the next. While the load control is high, the holding bank copies the shift register on every system-clock edge. This makes the bank transparent, one system clock behind the register. A build parameter sets the direction of travel through the channels.

Top module: `serpar_driver`

## Requirements
- R1: After asynchronous reset, the shift register and the holding bank are all zero and the serial output `sdata_o` is 0.
- R2: Each falling transition of `sclk_i` moves the register exactly one stage. Rising transitions and steady levels leave it unchanged.
- R3: With `SHIFT_UP`=1, new bits enter at channel 0 (`chan_o[0]`). `sdata_o` always equals the last stage (channel WIDTH-1). A word sent MSB first lands with bit k in channel k after WIDTH shifts.
- R4: A high-then-low pulse on `load_i` captures the register. While `load_i` stays low, the holding bank keeps its value even as shifting continues.
- R5: While `load_i` is held high, the holding bank follows the register, one system clock behind it.
- R6: When `blank_n_i`=0 and `pol_i`=0, every bit of `chan_o` is 1, whatever is held.
- R7: When `blank_n_i`=0 and `pol_i`=1, every bit of `chan_o` is 0.
- R8: When `blank_n_i`=1 and `pol_i`=1, `chan_o` equals the held bits: 1 means on.
- R9: When `blank_n_i`=1 and `pol_i`=0, `chan_o` is the bitwise inverse of the held bits.
- R10: With `SHIFT_UP`=0, bits enter at channel WIDTH-1, and `sdata_o` is channel 0. A word sent MSB first lands bit-reversed.
- R11: If `sdata_o` of one block feeds `sdata_i` of a second block on the same serial clock, the second block receives the stream exactly WIDTH shifts later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock. Shifting happens on its falling transition |
| sdata_i | input | 1 | Serial data in |
| load_i | input | 1 | Load control. A pulse captures; held high makes the bank transparent |
| blank_n_i | input | 1 | Active-low blanking. When low, all channels are forced |
| pol_i | input | 1 | Polarity select |
| sdata_o | output | 1 | Cascade output from the last shift stage |
| chan_o | output | WIDTH | Per-channel on/off controls |

## Verification
The assertions assume that `sclk_i` and `load_i` are synchronous to `clk` and that each level of `sclk_i` is held for at least one system clock. Under these conditions every falling transition is seen exactly once, and a detected fall can never be followed by another fall on the next cycle. The bench respects this: it changes every input on the inactive clock edge and holds each serial-clock level for a full system-clock period. It also requires WIDTH to be at least 2, so that the neighbour-stage checks refer to real stages.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int unsigned CH_DEFAULT = 32;

  typedef enum logic [1:0] {
    OM_FORCE_ON  = 2'd0,
    OM_FORCE_OFF = 2'd1,
    OM_INVERT    = 2'd2,
    OM_PASS      = 2'd3
  } out_mode_e;

  // blank_n low forces all channels; polarity picks on or off.
  // blank_n high passes held bits, inverted when polarity is low.
  function automatic out_mode_e decode_mode(input logic blank_n, input logic pol);
    out_mode_e m;
    case ({blank_n, pol})
      2'b00:   m = OM_FORCE_ON;
      2'b01:   m = OM_FORCE_OFF;
      2'b10:   m = OM_INVERT;
      default: m = OM_PASS;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/sp_fall_detect.sv
module sp_fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic fall_o
);
  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = level_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign fall_o = prev_q & ~level_i;

  // R2: a detected fall leaves the input low, so two falls in a row cannot happen
  a_r2_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/sp_shift_reg.sv
module sp_shift_reg #(
  parameter int WIDTH    = 32,
  parameter int SHIFT_UP = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             din,
  output logic [WIDTH-1:0] stages_o,
  output logic             tail_o
);
  logic [WIDTH-1:0] sr_q;
  logic [WIDTH-1:0] sr_d;

  generate
    if (SHIFT_UP != 0) begin : g_up
      always_comb begin
        sr_d = sr_q;
        if (shift_en) sr_d = {sr_q[WIDTH-2:0], din};
      end
      assign tail_o = sr_q[WIDTH-1];

      // R3: new bit lands in stage 0, neighbour moves upward
      a_r3_entry: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> sr_q[0] == $past(din));
      a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> sr_q[1] == $past(sr_q[0]));
    end else begin : g_down
      always_comb begin
        sr_d = sr_q;
        if (shift_en) sr_d = {din, sr_q[WIDTH-1:1]};
      end
      assign tail_o = sr_q[0];

      // R10: new bit lands in the top stage, neighbour moves downward
      a_r10_entry: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> sr_q[WIDTH-1] == $past(din));
      a_r10_advance: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> sr_q[WIDTH-2] == $past(sr_q[WIDTH-1]));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign stages_o = sr_q;

  // R2: no fall, no movement
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sr_q));
endmodule

// File: rtl/sp_hold_bank.sv
module sp_hold_bank #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] hold_q;
  logic [WIDTH-1:0] hold_d;

  always_comb begin
    hold_d = hold_q;
    if (load_i) hold_d = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assign q_o = hold_q;

  // R4: with load low the bank keeps its value
  a_r4_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(hold_q));
  // R5: with load high the bank tracks the register one clock later
  a_r5_follow: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> hold_q == $past(d_i));
endmodule

// File: rtl/sp_out_map.sv
module sp_out_map
  import sp_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blank_n_i,
  input  logic             pol_i,
  input  logic [WIDTH-1:0] held_i,
  output logic [WIDTH-1:0] chan_o
);
  out_mode_e mode;

  always_comb begin
    mode = decode_mode(blank_n_i, pol_i);
  end

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_ch
      always_comb begin
        case (mode)
          OM_FORCE_ON:  chan_o[i] = 1'b1;
          OM_FORCE_OFF: chan_o[i] = 1'b0;
          OM_INVERT:    chan_o[i] = ~held_i[i];
          default:      chan_o[i] = held_i[i];
        endcase
      end
    end
  endgenerate

  a_r6_all_on: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank_n_i && !pol_i) |-> (&chan_o));
  a_r7_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank_n_i && pol_i) |-> (chan_o == '0));
  a_r8_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_n_i && pol_i) |-> (chan_o == held_i));
  a_r9_inverted: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_n_i && !pol_i) |-> ((chan_o ^ held_i) == '1));
endmodule

// File: rtl/serpar_driver.sv
module serpar_driver #(
  parameter int WIDTH    = sp_pkg::CH_DEFAULT,
  parameter int SHIFT_UP = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_i,
  input  logic             sdata_i,
  input  logic             load_i,
  input  logic             blank_n_i,
  input  logic             pol_i,
  output logic             sdata_o,
  output logic [WIDTH-1:0] chan_o
);
  logic             shift_en;
  logic [WIDTH-1:0] stages;
  logic [WIDTH-1:0] held;

  initial begin
    if (WIDTH < 2) $error("WIDTH must be at least 2");
  end

  sp_fall_detect u_fall (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (sclk_i),
    .fall_o  (shift_en)
  );

  sp_shift_reg #(.WIDTH(WIDTH), .SHIFT_UP(SHIFT_UP)) u_sr (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .din      (sdata_i),
    .stages_o (stages),
    .tail_o   (sdata_o)
  );

  sp_hold_bank #(.WIDTH(WIDTH)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_i),
    .d_i    (stages),
    .q_o    (held)
  );

  sp_out_map #(.WIDTH(WIDTH)) u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .blank_n_i (blank_n_i),
    .pol_i     (pol_i),
    .held_i    (held),
    .chan_o    (chan_o)
  );

  // R3: the cascade output only changes on a shift
  a_r3_tail_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sdata_o));
endmodule

// File: tb/sim_serpar_driver.sv
module sim_serpar_driver;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic sclk, sdata, load, blank_n, pol;
  logic sdo0, sdo1, sdo2;
  logic [W-1:0] ch0, ch1, ch2;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [W-1:0] m0, m1, m2;

  always #4 clk = ~clk;

  serpar_driver #(.WIDTH(W), .SHIFT_UP(1)) u0 (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdata_i(sdata), .load_i(load),
    .blank_n_i(blank_n), .pol_i(pol), .sdata_o(sdo0), .chan_o(ch0));
  serpar_driver #(.WIDTH(W), .SHIFT_UP(1)) u1 (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdata_i(sdo0), .load_i(load),
    .blank_n_i(blank_n), .pol_i(pol), .sdata_o(sdo1), .chan_o(ch1));
  serpar_driver #(.WIDTH(W), .SHIFT_UP(0)) u2 (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdata_i(sdata), .load_i(load),
    .blank_n_i(blank_n), .pol_i(pol), .sdata_o(sdo2), .chan_o(ch2));

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    sdata = b;
    sclk  = 1'b1;
    @(negedge clk);
    sclk  = 1'b0;
    @(negedge clk);
    m1 = {m1[W-2:0], m0[W-1]};
    m0 = {m0[W-2:0], b};
    m2 = {b, m2[W-1:1]};
  endtask

  task automatic shift_word(input logic [W-1:0] w, input bit check_tail);
    for (int i = W - 1; i >= 0; i--) begin
      shift_bit(w[i]);
      if (check_tail) chk("R3 sdata_o tracks last stage", {31'd0, sdo0}, {31'd0, m0[W-1]});
    end
  endtask

  task automatic pulse_load();
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; sclk = 1'b0; sdata = 1'b0; load = 1'b0; blank_n = 1'b1; pol = 1'b1;
    m0 = '0; m1 = '0; m2 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs off after reset", ch0, '0);
    chk("R1 sdata_o low after reset", {31'd0, sdo0}, '0);
    pol = 1'b0;
    @(negedge clk);
    chk("R1 inverted view of zero bank", ch0, '1);
    pol = 1'b1;
  endtask

  task automatic t_shift_and_modes(input logic [W-1:0] w);
    shift_word(w, 1'b1);
    pulse_load();
    blank_n = 1'b1; pol = 1'b1; @(negedge clk);
    chk("R8 direct mapping", ch0, w);
    chk("R3 word MSB first lands in order", ch0, m0);
    blank_n = 1'b1; pol = 1'b0; @(negedge clk);
    chk("R9 inverted mapping", ch0, ~w);
    blank_n = 1'b0; pol = 1'b0; @(negedge clk);
    chk("R6 all forced on", ch0, '1);
    blank_n = 1'b0; pol = 1'b1; @(negedge clk);
    chk("R7 all forced off", ch0, '0);
    blank_n = 1'b1; pol = 1'b1; @(negedge clk);
  endtask

  task automatic t_hold_and_edges();
    logic [W-1:0] a, b;
    a = $urandom; b = ~a ^ 32'h0F0F_1234;
    shift_word(a, 1'b0);
    pulse_load();
    shift_word(b, 1'b0);
    chk("R4 bank holds while load low", ch0, a);
    // rising edge and steady high only: no shift
    sdata = ~sdata;
    sclk = 1'b1;
    repeat (3) @(negedge clk);
    pulse_load();
    chk("R2 rising edge does not shift", ch0, b);
    sclk = 1'b0;
    @(negedge clk);
    pulse_load();
    chk("R2 one fall gives one shift", ch0, {b[W-2:0], sdata});
    m1 = {m1[W-2:0], m0[W-1]};
    m0 = {m0[W-2:0], sdata};
    m2 = {sdata, m2[W-1:1]};
  endtask

  task automatic t_transparent();
    load = 1'b1;
    for (int i = 0; i < 8; i++) begin
      shift_bit($urandom % 2);
      @(negedge clk);
      chk("R5 transparent follows register", ch0, m0);
    end
    load = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reverse();
    logic [W-1:0] w, rev;
    w = $urandom;
    for (int i = 0; i < W; i++) rev[i] = w[W-1-i];
    shift_word(w, 1'b0);
    pulse_load();
    chk("R10 reverse direction bit-reversed", ch2, rev);
    chk("R10 reverse tail is channel 0", {31'd0, sdo2}, {31'd0, rev[0]});
  endtask

  task automatic t_cascade();
    logic [W-1:0] a, b;
    a = $urandom; b = $urandom;
    shift_word(a, 1'b0);
    shift_word(b, 1'b0);
    pulse_load();
    chk("R11 second block holds first word", ch1, a);
    chk("R11 first block holds second word", ch0, b);
    chk("R11 second block tail", {31'd0, sdo1}, {31'd0, a[W-1]});
  endtask

  initial begin
    t_reset();
    t_shift_and_modes(32'hA5C3_0FF1);
    t_shift_and_modes($urandom);
    t_shift_and_modes(32'h8000_0001);
    t_hold_and_edges();
    t_transparent();
    t_reverse();
    t_cascade();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule